// File: doc/BRIEF.md
# Video Information Packet Builder

This block assembles the 17-byte auxiliary video information packet that a display transmitter sends alongside active video. It starts from the current display mode: the pixel clock in kHz and the active width and height. From these it derives two things, the colorimetry class and the picture aspect class. It then works out the checksum so that the packet bytes sum to zero modulo 256. Finally it writes the packet, one byte per cycle, into a packet RAM through a simple address, data and write-enable port.

A one-cycle start strobe sets a run going. The block captures the mode inputs on that edge. A restoring divider then forms floor(width*100/height), one quotient bit per cycle. When the division is finished, every byte is known, and the packet goes out in index order from 0 to 16. A one-cycle done pulse marks the end of the run. Any start seen before the block has gone back to idle is dropped.

Top module: `avi_pkt_builder`

## Requirements
- R1: After reset, the write enable and the done flag are both low, and they stay low until a start is given.
- R2: A run writes exactly 17 bytes, on 17 consecutive cycles, at addresses 0, 1, 2 and so on up to 16. The first write appears NUM_W+1 cycles after the start edge, where NUM_W is RES_W+7.
- R3: The fixed bytes have these values: byte 0 is 0x82, byte 1 is 0x02, byte 2 is 0x0D, byte 4 is 0x12, byte 6 is 0x88. Bytes 7 to 16 are 0x00.
- R4: The colorimetry bits of byte 5 are 0x40 when the pixel clock is at most 27000 kHz, and 0x80 when it is above that.
- R5: The aspect bits of byte 5 are 0x18 when floor(width*100/height) is less than 156, and 0x28 when it is 156 or more. Byte 5 is the colorimetry bits ORed with the aspect bits.
- R6: Byte 3 holds the checksum: (0x100 minus the 8-bit sum of all the other bytes) mod 256. As a result, all 17 written bytes add up to 0 mod 256.
- R7: Done is high for exactly one cycle. That cycle is the one right after the write of byte 16, and write enable is low during it.
- R8: A start that arrives while a run is in progress has no effect. The run in progress keeps its captured inputs, and only 17 writes occur.
- R9: A height of zero gives the 16:9 aspect bits (0x28), because the divider then returns an all-ones quotient.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle request to build a packet |
| pixClkKhz | input | CLK_W | Pixel clock in kHz, captured at start |
| hActive | input | RES_W | Active width in pixels, captured at start |
| vActive | input | RES_W | Active height in lines, captured at start |
| wrAddr | output | IDX_W | Packet RAM byte address |
| wrData | output | 8 | Packet RAM byte data |
| wrEn | output | 1 | Packet RAM write enable |
| done | output | 1 | One-cycle end-of-run pulse |

## Verification
The case hardest to reach from the ports is a second start that arrives while the divider is still running. The bench pulses start partway through the division, with a different mode on the inputs, and then checks that the captured packet still matches the first mode and that there are still exactly 17 writes. The aspect threshold is probed with modes whose ratio lands on 155 and on exactly 156. The colorimetry threshold is probed at 27000 and at 27001 kHz. A zero height drives the divider into its divide-by-zero result.

// File: rtl/avi_pkt_pkg.sv
package avi_pkt_pkg;
  localparam int PKT_LEN = 17;
  localparam int IDX_W   = $clog2(PKT_LEN);
  localparam int CHK_IDX = 3;
  localparam int FMT_IDX = 5;

  typedef struct packed {
    logic load;
    logic step;
  } avi_ctl_t;

  function automatic logic [7:0] baseByte(input logic [IDX_W-1:0] idx);
    case (idx)
      5'd0:    baseByte = 8'h82;
      5'd1:    baseByte = 8'h02;
      5'd2:    baseByte = 8'h0D;
      5'd4:    baseByte = 8'h12;
      5'd6:    baseByte = 8'h88;
      default: baseByte = 8'h00;
    endcase
  endfunction

  function automatic logic [7:0] baseSum();
    logic [7:0] acc;
    acc = 8'h00;
    for (int i = 0; i < PKT_LEN; i++) acc = acc + baseByte(IDX_W'(i));
    return acc;
  endfunction
endpackage

// File: rtl/avi_pkt_dp.sv
module avi_pkt_dp
  import avi_pkt_pkg::*;
#(
  parameter int CLK_W    = 20,
  parameter int RES_W    = 12,
  parameter int SD_LIMIT = 27000,
  parameter int ASP_LIM  = 156
) (
  input  logic             clk,
  input  logic             rstN,
  input  avi_ctl_t         ctl,
  input  logic [IDX_W-1:0] idx,
  input  logic [CLK_W-1:0] pixClkKhz,
  input  logic [RES_W-1:0] hActive,
  input  logic [RES_W-1:0] vActive,
  output logic [7:0]       byteOut
);
  localparam int NUM_W = RES_W + 7;

  logic             sdR;
  logic [RES_W-1:0] denR;
  logic [RES_W:0]   remR;
  logic [NUM_W-1:0] quoR;
  logic [RES_W:0]   trial;
  logic             fits;
  logic [7:0]       fmtByte;
  logic [7:0]       chkByte;

  assign trial = {remR[RES_W-1:0], quoR[NUM_W-1]};
  assign fits  = trial >= {1'b0, denR};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sdR  <= 1'b0;
      denR <= '0;
      remR <= '0;
      quoR <= '0;
    end else if (ctl.load) begin
      sdR  <= pixClkKhz <= CLK_W'(SD_LIMIT);
      denR <= vActive;
      remR <= '0;
      quoR <= NUM_W'(hActive) * NUM_W'(100);
    end else if (ctl.step) begin
      remR <= fits ? trial - {1'b0, denR} : trial;
      quoR <= {quoR[NUM_W-2:0], fits};
    end
  end

  assign fmtByte = (sdR ? 8'h40 : 8'h80) |
                   ((quoR < NUM_W'(ASP_LIM)) ? 8'h18 : 8'h28);
  assign chkByte = 8'h00 - (baseSum() + fmtByte);

  always_comb begin
    if (idx == IDX_W'(CHK_IDX))      byteOut = chkByte;
    else if (idx == IDX_W'(FMT_IDX)) byteOut = fmtByte;
    else                             byteOut = baseByte(idx);
  end

  // R5: the remainder never reaches the divisor after a step
  p_rem_below_den_r5: assert property (@(posedge clk) disable iff (!rstN)
    ($past(ctl.step) && denR != '0) |-> remR < {1'b0, denR});
endmodule

// File: rtl/avi_pkt_ctrl.sv
module avi_pkt_ctrl
  import avi_pkt_pkg::*;
#(
  parameter int NUM_W = 19
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  output avi_ctl_t         ctl,
  output logic [IDX_W-1:0] idx,
  output logic             wrEn,
  output logic             done
);
  localparam int CNT_W = $clog2(NUM_W + 1);

  typedef enum logic [1:0] {S_IDLE, S_DIV, S_WRITE, S_FIN} state_t;

  state_t           stateR;
  logic [CNT_W-1:0] stepCnt;
  logic [IDX_W-1:0] idxR;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateR  <= S_IDLE;
      stepCnt <= '0;
      idxR    <= '0;
    end else begin
      case (stateR)
        S_IDLE: if (start) begin
          stateR  <= S_DIV;
          stepCnt <= '0;
        end
        S_DIV: begin
          stepCnt <= stepCnt + 1'b1;
          if (stepCnt == CNT_W'(NUM_W - 1)) begin
            stateR <= S_WRITE;
            idxR   <= '0;
          end
        end
        S_WRITE: begin
          idxR <= idxR + 1'b1;
          if (idxR == IDX_W'(PKT_LEN - 1)) stateR <= S_FIN;
        end
        default: stateR <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    ctl.load = (stateR == S_IDLE) && start;
    ctl.step = (stateR == S_DIV);
  end

  assign idx  = idxR;
  assign wrEn = (stateR == S_WRITE);
  assign done = (stateR == S_FIN);

  p_addr_step_r2: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && idx != IDX_W'(PKT_LEN - 1)) |=> (wrEn && idx == $past(idx) + 1'b1));
  p_first_addr_r2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(wrEn) |-> idx == '0);
  p_done_after_last_r7: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && idx == IDX_W'(PKT_LEN - 1)) |=> done);
  p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
  p_done_no_write_r7: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !wrEn);
  p_busy_ignores_start_r8: assert property (@(posedge clk) disable iff (!rstN)
    (start && stateR == S_DIV) |=> stateR != S_IDLE);
endmodule

// File: rtl/avi_pkt_builder.sv
module avi_pkt_builder
  import avi_pkt_pkg::*;
#(
  parameter int CLK_W    = 20,
  parameter int RES_W    = 12,
  parameter int SD_LIMIT = 27000,
  parameter int ASP_LIM  = 156
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic [CLK_W-1:0] pixClkKhz,
  input  logic [RES_W-1:0] hActive,
  input  logic [RES_W-1:0] vActive,
  output logic [IDX_W-1:0] wrAddr,
  output logic [7:0]       wrData,
  output logic             wrEn,
  output logic             done
);
  localparam int NUM_W = RES_W + 7;

  avi_ctl_t         ctl;
  logic [IDX_W-1:0] idx;

  avi_pkt_ctrl #(.NUM_W(NUM_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .start(start),
    .ctl(ctl), .idx(idx), .wrEn(wrEn), .done(done)
  );

  avi_pkt_dp #(.CLK_W(CLK_W), .RES_W(RES_W), .SD_LIMIT(SD_LIMIT), .ASP_LIM(ASP_LIM)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .idx(idx),
    .pixClkKhz(pixClkKhz), .hActive(hActive), .vActive(vActive),
    .byteOut(wrData)
  );

  assign wrAddr = idx;
endmodule

// File: tb/avi_pkt_builder_bench.sv
module avi_pkt_builder_bench;
  import avi_pkt_pkg::*;
  localparam int CLK_W = 20;
  localparam int RES_W = 12;
  localparam int NUM_W = RES_W + 7;

  typedef struct packed {
    logic [CLK_W-1:0] pclk;
    logic [RES_W-1:0] x;
    logic [RES_W-1:0] y;
    logic [7:0]       b5;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VEC [NV] = '{
    '{20'd25175,  12'd640,  12'd480,  8'h58},
    '{20'd27000,  12'd720,  12'd480,  8'h58},
    '{20'd27001,  12'd720,  12'd480,  8'h98},
    '{20'd74250,  12'd1280, 12'd720,  8'hA8},
    '{20'd148500, 12'd1920, 12'd1080, 8'hA8},
    '{20'd27000,  12'd1248, 12'd800,  8'h68},
    '{20'd30000,  12'd1247, 12'd800,  8'h98},
    '{20'd25200,  12'd1920, 12'd1080, 8'h68}
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic [CLK_W-1:0] pixClkKhz = '0;
  logic [RES_W-1:0] hActive = '0;
  logic [RES_W-1:0] vActive = '0;
  logic [IDX_W-1:0] wrAddr;
  logic [7:0] wrData;
  logic wrEn, done;

  int nChecks = 0;
  int nFails = 0;
  int cyc = 0;

  logic [7:0] pkt [PKT_LEN];
  int nWrites, firstWr, doneAt, doneCnt;
  logic orderOk;

  always #2.5 clk = ~clk;

  avi_pkt_builder u_avi_pkt_builder (
    .clk(clk), .rstN(rstN), .start(start), .pixClkKhz(pixClkKhz),
    .hActive(hActive), .vActive(vActive), .wrAddr(wrAddr),
    .wrData(wrData), .wrEn(wrEn), .done(done)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      nFails = nFails + 1;
      $display("FAIL watchdog: run hung, got %0d cycles, expected fewer", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // Runs one packet; if busyStart, a second start with another mode comes mid-division.
  task automatic runPkt(input logic [CLK_W-1:0] pc, input logic [RES_W-1:0] x,
                        input logic [RES_W-1:0] y, input bit busyStart);
    int lastAddr;
    @(negedge clk);
    pixClkKhz = pc; hActive = x; vActive = y; start = 1'b1;
    nWrites = 0; firstWr = -1; doneAt = -1; doneCnt = 0; orderOk = 1'b1; lastAddr = -1;
    for (int i = 0; i < PKT_LEN; i++) pkt[i] = 8'hEE;
    for (int n = 1; n <= NUM_W + PKT_LEN + 10; n++) begin
      @(negedge clk);
      start = 1'b0;
      if (busyStart && n == 5) begin
        start = 1'b1; pixClkKhz = 20'd100000; hActive = 12'd100; vActive = 12'd100;
      end
      if (busyStart && n == NUM_W + 4) start = 1'b1;
      if (busyStart && n == NUM_W + 5) start = 1'b0;
      if (wrEn) begin
        if (firstWr < 0) firstWr = n;
        if (int'(wrAddr) != lastAddr + 1 || n != firstWr + nWrites) orderOk = 1'b0;
        lastAddr = int'(wrAddr);
        if (int'(wrAddr) < PKT_LEN) pkt[wrAddr] = wrData;
        nWrites++;
      end
      if (done) begin
        doneCnt++;
        if (doneAt < 0) doneAt = n;
      end
    end
    start = 1'b0;
  endtask

  task automatic checkPkt(input string tag, input logic [7:0] b5);
    logic [7:0] s;
    s = 8'h00;
    for (int i = 0; i < PKT_LEN; i++) s = s + pkt[i];
    check({tag, " R2 write count"}, nWrites, PKT_LEN);
    check({tag, " R2 in-order contiguous"}, int'(orderOk), 1);
    check({tag, " R2 first write latency"}, firstWr, NUM_W + 1);
    check({tag, " R3 byte0"}, pkt[0], 8'h82);
    check({tag, " R3 byte2"}, pkt[2], 8'h0D);
    check({tag, " R3 byte6"}, pkt[6], 8'h88);
    check({tag, " R3 byte16"}, pkt[16], 8'h00);
    check({tag, " R4/R5 byte5"}, pkt[5], b5);
    check({tag, " R6 checksum byte"}, pkt[3], (8'h00 - (8'h2B + b5)) & 8'hFF);
    check({tag, " R6 zero sum"}, s, 0);
    check({tag, " R7 done cycle"}, doneAt, firstWr + PKT_LEN);
    check({tag, " R7 done single"}, doneCnt, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state held and then idle with no start
    check("R1 wrEn in reset", int'(wrEn), 0);
    check("R1 done in reset", int'(done), 0);
    rstN = 1'b1;
    repeat (5) @(negedge clk);
    check("R1 wrEn idle", int'(wrEn), 0);
    check("R1 done idle", int'(done), 0);

    for (int v = 0; v < NV; v++) begin
      runPkt(VEC[v].pclk, VEC[v].x, VEC[v].y, 1'b0);
      checkPkt($sformatf("vec%0d", v), VEC[v].b5);
    end

    // R9: zero height gives wide aspect bits
    runPkt(20'd25000, 12'd640, 12'd0, 1'b0);
    checkPkt("R9 zero height", 8'h68);

    // R8: start during division and during writes is ignored
    runPkt(20'd74250, 12'd640, 12'd480, 1'b1);
    checkPkt("R8 busy start", 8'h98);
    repeat (NUM_W + PKT_LEN + 5) @(negedge clk);
    check("R8 no extra run wrEn", int'(wrEn), 0);
    check("R8 no extra run done", int'(done), 0);

    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule